// File: doc/BRIEF.md
# Flash Word-Program and Erase Sequencer

This block is a small register-mapped controller placed between a processor bus and an on-chip data flash array (modelled here as a synchronous memory). Software uses it to program a single 16-bit word, to erase one sector, or to erase the whole array. Every operation needs two things. An enable bit in the control register must be set. The access register must also be armed with a two-byte key. One arming covers exactly one operation.

The target word is chosen by two registers. A segment register picks the sector and an offset register picks the word inside it. A write to the data register starts a word program. Writing a 1 to one of the two erase bits in the control register starts an erase. For the whole length of an operation the `stall` output holds the processor. The length comes from cycle counters. An erase clears its region one word per cycle to all ones and then waits a further tail period. Register reads, including a read of the flash word at the loaded address, return after a fixed latency.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A program or erase is accepted only while the enable bit (control bit 0) is 1. For a control-register write, the enable value carried in that same write is the one used. A rejected command changes no flash word and never raises `stall`.
- R2: Writing 0xFA and then 0xF5 (low byte) to the key register (address 1) arms the controller while enable is 1. The reverse order leaves it unarmed.
- R3: After 0xFA, any accepted write other than 0xF5 to the key register returns the arming state to unarmed. This covers writes to other registers.
- R4: An accepted program or erase disarms the controller. The next command needs a new key sequence.
- R5: The word address is {segment, offset}. The segment register (address 2) selects the sector of SECTOR_WORDS words and the offset register (address 3) selects the word within it.
- R6: Writing the data register (address 4) while armed stores that value at the loaded address. Reading address 4 returns the word at the loaded address.
- R7: Writing control bit 1 = 1 while armed sets every word of the sector chosen by the segment register to 0xFFFF and leaves the other sectors unchanged.
- R8: Writing control bit 2 = 1 while armed sets every word to 0xFFFF. When bits 1 and 2 are both 1 in one write, the whole-array erase is performed.
- R9: `stall` rises on the cycle after the launching write. It stays high for PROG_CYCLES cycles for a program, SECTOR_WORDS+ERASE_TAIL cycles for a sector erase, and SECTORS*SECTOR_WORDS+ERASE_TAIL cycles for a whole-array erase.
- R10: A program or erase request that is rejected sets the error flag (control bit 3). The flag stays set until a control write with bit 3 = 1 clears it. If that same write also makes a rejected request, the flag stays set.
- R11: Bus writes presented while `stall` is high are ignored. They change no register, no arming state and no flash word.
- R12: A read pulse on `bus_re` is answered two cycles later with `bus_rvalid` high for one cycle. Control reads return enable in bit 0 and the error flag in bit 3, and the erase bits read as 0. Segment and offset read back zero-extended. The key register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select: 0 control, 1 key, 2 segment, 3 offset, 4 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| stall | output | 1 | Processor hold while an operation runs |

## Verification
Two things can be decided in the same cycle. The first is a sector erase and a whole-array erase, when one control write sets both bits. The second is a change to the enable bit together with an erase request, when one write clears enable and asks for an erase. The bench makes both writes while armed. In the first case it judges the result by the stall length, which must match the whole-array count, and by reading words in both sectors as 0xFFFF. In the second case it checks that `stall` stays low, that a previously programmed word survives, and that the error flag reads back as set.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam logic [2:0] REG_CTL  = 3'd0;
  localparam logic [2:0] REG_KEY  = 3'd1;
  localparam logic [2:0] REG_SEG  = 3'd2;
  localparam logic [2:0] REG_OFF  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;

  localparam int CTL_EN  = 0;
  localparam int CTL_SEC = 1;
  localparam int CTL_BLK = 2;
  localparam int CTL_ERR = 3;

  localparam logic [7:0] KEY_A = 8'hFA;
  localparam logic [7:0] KEY_B = 8'hF5;

  typedef enum logic [1:0] {
    ARM_OFF  = 2'd0,
    ARM_HALF = 2'd1,
    ARM_ON   = 2'd2
  } arm_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_WALK = 2'd2,
    OP_TAIL = 2'd3
  } op_e;

endpackage

// File: rtl/fc_unlock.sv
module fc_unlock
  import fc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wr,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       drop,
  input  logic       consume,
  output logic       armed
);

  arm_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (drop || consume || !en) begin
      st_d = ARM_OFF;
    end else begin
      case (st_q)
        ARM_OFF:  if (key_wr && key_byte == KEY_A) st_d = ARM_HALF;
        ARM_HALF: if (wr) st_d = (key_wr && key_byte == KEY_B) ? ARM_ON : ARM_OFF;
        ARM_ON:   if (key_wr) st_d = (key_byte == KEY_A) ? ARM_HALF : ARM_OFF;
        default:  st_d = ARM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ARM_OFF;
    else     st_q <= st_d;
  end

  assign armed = (st_q == ARM_ON);

  // R4: a launched command always leaves the controller disarmed
  p_consume_disarms_r4: assert property (@(posedge clk) disable iff (rst)
    consume |=> (st_q == ARM_OFF));

  // R3: half-way through the key, a non-matching write drops back
  p_bad_second_key_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARM_HALF && wr && !(key_wr && key_byte == KEY_B)) |=> (st_q == ARM_OFF));

  // R2: arming is only reachable from the half state
  p_arm_order_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARM_OFF) |=> (st_q != ARM_ON));

endmodule

// File: rtl/fc_array.sv
module fc_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fc_seq.sv
module fc_seq
  import fc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SEG_W        = 1,
  parameter int OFF_W        = 9,
  parameter int SECTORS      = 2,
  parameter int SECTOR_WORDS = 512,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_TAIL   = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go_prog,
  input  logic                    go_sec,
  input  logic                    go_blk,
  input  logic [SEG_W-1:0]        sec_sel,
  input  logic [SEG_W+OFF_W-1:0]  addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    busy,
  output logic                    mem_we,
  output logic [SEG_W+OFF_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata
);

  localparam int AW      = SEG_W + OFF_W;
  localparam int TOTAL   = SECTORS * SECTOR_WORDS;
  localparam int MAXC    = (TOTAL > ERASE_TAIL) ?
                           ((TOTAL > PROG_CYCLES) ? TOTAL : PROG_CYCLES) :
                           ((ERASE_TAIL > PROG_CYCLES) ? ERASE_TAIL : PROG_CYCLES);
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] C_PROG = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] C_SEC  = CNT_W'(SECTOR_WORDS - 1);
  localparam logic [CNT_W-1:0] C_BLK  = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] C_TAIL = CNT_W'(ERASE_TAIL - 1);

  op_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [AW-1:0]     wa_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
      wa_q  <= '0;
      wd_q  <= '0;
    end else begin
      case (st_q)
        OP_IDLE: begin
          if (go_blk) begin
            st_q  <= OP_WALK;
            wa_q  <= '0;
            cnt_q <= C_BLK;
          end else if (go_sec) begin
            st_q  <= OP_WALK;
            wa_q  <= {sec_sel, {OFF_W{1'b0}}};
            cnt_q <= C_SEC;
          end else if (go_prog) begin
            st_q  <= OP_PROG;
            wa_q  <= addr;
            wd_q  <= wdata;
            cnt_q <= C_PROG;
          end
        end
        OP_PROG: begin
          if (cnt_q == '0) st_q <= OP_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        OP_WALK: begin
          wa_q <= wa_q + 1'b1;
          if (cnt_q == '0) begin
            st_q  <= OP_TAIL;
            cnt_q <= C_TAIL;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        OP_TAIL: begin
          if (cnt_q == '0) st_q <= OP_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= OP_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != OP_IDLE);
  assign mem_we    = (st_q == OP_WALK) || (st_q == OP_PROG && cnt_q == CNT_W'(1));
  assign mem_waddr = wa_q;
  assign mem_wdata = (st_q == OP_PROG) ? wd_q : '1;

  // R9: a launch from idle raises busy on the next cycle
  p_launch_busy_r9: assert property (@(posedge clk) disable iff (rst)
    ((go_prog || go_sec || go_blk) && !busy) |=> busy);

  // R9: the last busy cycle never writes, so a read after the stall sees the result
  p_quiet_last_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(mem_we));

  // R9: program holds while its counter is running
  p_prog_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == OP_PROG && cnt_q != '0) |=> (st_q == OP_PROG));

  // R11: the front end never launches while an operation runs
  p_no_launch_busy_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(go_prog || go_sec || go_blk));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SECTORS      = 2,
  parameter int SECTOR_WORDS = 512,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_TAIL   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              stall
);

  localparam int SEG_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int OFF_W = $clog2(SECTOR_WORDS);
  localparam int AW    = SEG_W + OFF_W;
  localparam int TOTAL = SECTORS * SECTOR_WORDS;

  logic              busy;
  logic              en_q, err_q;
  logic [SEG_W-1:0]  seg_q;
  logic [OFF_W-1:0]  off_q;
  logic              armed;

  logic              wr, ctl_wr, key_wr, seg_wr, off_wr, data_wr;
  logic              new_en, ok;
  logic              req_prog, req_sec, req_blk;
  logic              go_prog, go_sec, go_blk, reject;

  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_q;

  logic              rd_pend_q;
  logic [2:0]        rd_sel_q;

  // front-end decode; everything is ignored while an operation runs
  assign wr      = bus_we && !busy;
  assign ctl_wr  = wr && bus_addr == REG_CTL;
  assign key_wr  = wr && bus_addr == REG_KEY;
  assign seg_wr  = wr && bus_addr == REG_SEG;
  assign off_wr  = wr && bus_addr == REG_OFF;
  assign data_wr = wr && bus_addr == REG_DATA;

  assign new_en   = ctl_wr ? bus_wdata[CTL_EN] : en_q;
  assign ok       = armed && new_en;
  assign req_prog = data_wr;
  assign req_blk  = ctl_wr && bus_wdata[CTL_BLK];
  assign req_sec  = ctl_wr && bus_wdata[CTL_SEC] && !bus_wdata[CTL_BLK];
  assign go_prog  = req_prog && ok;
  assign go_sec   = req_sec && ok;
  assign go_blk   = req_blk && ok;
  assign reject   = (req_prog || req_sec || req_blk) && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
      seg_q <= '0;
      off_q <= '0;
    end else begin
      if (ctl_wr) en_q <= bus_wdata[CTL_EN];
      if (seg_wr) seg_q <= bus_wdata[SEG_W-1:0];
      if (off_wr) off_q <= bus_wdata[OFF_W-1:0];
      if (reject)                             err_q <= 1'b1;
      else if (ctl_wr && bus_wdata[CTL_ERR])  err_q <= 1'b0;
    end
  end

  fc_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .wr       (wr),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .drop     (ctl_wr && !bus_wdata[CTL_EN]),
    .consume  (go_prog || go_sec || go_blk),
    .armed    (armed)
  );

  fc_seq #(
    .DATA_W       (DATA_W),
    .SEG_W        (SEG_W),
    .OFF_W        (OFF_W),
    .SECTORS      (SECTORS),
    .SECTOR_WORDS (SECTOR_WORDS),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_TAIL   (ERASE_TAIL)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go_prog   (go_prog),
    .go_sec    (go_sec),
    .go_blk    (go_blk),
    .sec_sel   (seg_q),
    .addr      ({seg_q, off_q}),
    .wdata     (bus_wdata),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  fc_array #(
    .DATA_W (DATA_W),
    .DEPTH  (TOTAL),
    .AW     (AW)
  ) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr ({seg_q, off_q}),
    .rdata (mem_q)
  );

  // two-stage read path: array read, then output mux register
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_sel_q   <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rd_pend_q  <= bus_re;
      rd_sel_q   <= bus_addr;
      bus_rvalid <= rd_pend_q;
      if (rd_pend_q) begin
        case (rd_sel_q)
          REG_CTL: begin
            bus_rdata          <= '0;
            bus_rdata[CTL_EN]  <= en_q;
            bus_rdata[CTL_ERR] <= err_q;
          end
          REG_SEG:  bus_rdata <= DATA_W'(seg_q);
          REG_OFF:  bus_rdata <= DATA_W'(off_q);
          REG_DATA: bus_rdata <= mem_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign stall = busy;

  // R10: the error flag only drops on an explicit clearing control write
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(bus_we && !stall && bus_addr == REG_CTL && bus_wdata[CTL_ERR])) |=> err_q);

  // R11: writes during a stall leave the address and enable registers alone
  p_stall_ignores_r11: assert property (@(posedge clk) disable iff (rst)
    (stall && bus_we) |=> ($stable(seg_q) && $stable(off_q) && $stable(en_q)));

  // R1: with enable low nothing is launched
  p_enable_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !stall && !(bus_we && bus_addr == REG_CTL)) |=> !stall);

  // R12: read data is valid exactly two cycles after the request
  p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
    $past(bus_re, 2) |-> bus_rvalid);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

  localparam int DW    = 16;
  localparam int SECS  = 2;
  localparam int SW    = 512;
  localparam int PC    = 8;
  localparam int TAIL  = 64;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_KEY  = 3'd1;
  localparam logic [2:0] A_SEG  = 3'd2;
  localparam logic [2:0] A_OFF  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic          stall;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #4 clk = ~clk;

  flash_cmd_ctrl #(
    .DATA_W (DW), .SECTORS (SECS), .SECTOR_WORDS (SW),
    .PROG_CYCLES (PC), .ERASE_TAIL (TAIL)
  ) u_dut (
    .clk (clk), .rst (rst), .bus_we (bus_we), .bus_re (bus_re),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid), .stall (stall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12: unexpected read data actual=0x%0h expected=none", bus_rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, int'(bus_rdata), int'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (stall && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock();
    wr(A_KEY, 16'h00FA);
    wr(A_KEY, 16'h00F5);
  endtask

  task automatic peek(input int s, input int o, input logic [DW-1:0] e, input string t);
    wr(A_SEG, DW'(s));
    wr(A_OFF, DW'(o));
    rd(A_DATA, e, t);
  endtask

  task automatic prog(input int s, input int o, input logic [DW-1:0] v, input string t);
    int n;
    wr(A_SEG, DW'(s));
    wr(A_OFF, DW'(o));
    unlock();
    wr(A_DATA, v);
    wait_idle(n);
    chk(t, n, PC);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R9 stall low after reset", int'(stall), 0);
    rd(A_CTL, 16'h0000, "R12 ctl reset");
    rd(A_SEG, 16'h0000, "R12 seg reset");
    rd(A_KEY, 16'h0000, "R12 key reads zero");

    // R1: command with enable low is rejected and flagged
    wr(A_SEG, 16'd1); wr(A_OFF, 16'd2);
    unlock();
    wr(A_DATA, 16'hDEAD);
    chk("R1 no stall when disabled", int'(stall), 0);
    rd(A_CTL, 16'h0008, "R1 error after disabled program");
    peek(1, 2, 16'hFFFF, "R1 word untouched");
    wr(A_CTL, 16'h0008);
    rd(A_CTL, 16'h0000, "R10 error cleared by write-one");

    // R2: reversed key order stays locked
    wr(A_CTL, 16'h0001);
    wr(A_KEY, 16'h00F5); wr(A_KEY, 16'h00FA);
    wr(A_DATA, 16'h1111);
    chk("R2 reversed key no stall", int'(stall), 0);
    rd(A_CTL, 16'h0009, "R2 reversed key flags error");
    wr(A_CTL, 16'h0009);
    rd(A_CTL, 16'h0001, "R10 clear keeps enable");

    // R3: interleaved write and wrong second byte relock
    wr(A_KEY, 16'h00FA); wr(A_OFF, 16'd2); wr(A_KEY, 16'h00F5);
    wr(A_DATA, 16'h2222);
    chk("R3 interleaved write relocks", int'(stall), 0);
    wr(A_KEY, 16'h00FA); wr(A_KEY, 16'h0012); wr(A_KEY, 16'h00F5);
    wr(A_DATA, 16'h3333);
    chk("R3 wrong second byte relocks", int'(stall), 0);
    rd(A_CTL, 16'h0009, "R3 error set");
    wr(A_CTL, 16'h0009);

    // R6/R9: a word program
    prog(1, 5, 16'h1234, "R9 program stall length");
    peek(1, 5, 16'h1234, "R6 program readback");
    rd(A_CTL, 16'h0001, "R6 no error after good program");

    // R4: unlock is used up
    wr(A_DATA, 16'h9999);
    chk("R4 second command without key no stall", int'(stall), 0);
    peek(1, 5, 16'h1234, "R4 word unchanged");
    rd(A_CTL, 16'h0009, "R4 error after reused unlock");
    wr(A_CTL, 16'h0009);

    // R5: sector and offset mapping
    prog(0, 5, 16'hABCD, "R9 program stall length sector0");
    prog(0, SW - 1, 16'h5555, "R9 program stall last word");
    peek(0, 5, 16'hABCD, "R5 sector0 word");
    peek(1, 5, 16'h1234, "R5 sector1 word separate");
    peek(0, SW - 1, 16'h5555, "R5 last word of sector0");
    peek(1, 0, 16'hFFFF, "R5 first word of sector1 untouched");
    rd(A_SEG, 16'h0001, "R12 seg readback");
    rd(A_OFF, 16'h0000, "R12 off readback");

    // R11: writes during a stall are ignored
    wr(A_SEG, 16'd1); wr(A_OFF, 16'd7);
    unlock();
    wr(A_DATA, 16'h7777);
    bus_we = 1'b1; bus_addr = A_OFF; bus_wdata = 16'd3;
    @(negedge clk);
    bus_addr = A_DATA; bus_wdata = 16'h1111;
    @(negedge clk);
    bus_addr = A_CTL; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_we = 1'b0;
    wait_idle(n);
    chk("R9 stall length with blocked writes", n + 3, PC);
    rd(A_OFF, 16'h0007, "R11 offset kept");
    rd(A_CTL, 16'h0001, "R11 enable kept, no error");
    peek(1, 7, 16'h7777, "R11 programmed value kept");
    peek(1, 3, 16'hFFFF, "R11 no stray program");

    // R7: sector erase of sector 1
    wr(A_SEG, 16'd1);
    unlock();
    wr(A_CTL, 16'h0003);
    wait_idle(n);
    chk("R9 sector erase stall length", n, SW + TAIL);
    peek(1, 5, 16'hFFFF, "R7 erased sector word5");
    peek(1, 7, 16'hFFFF, "R7 erased sector word7");
    peek(0, 5, 16'hABCD, "R7 other sector kept");
    peek(0, SW - 1, 16'h5555, "R7 other sector last word kept");
    rd(A_CTL, 16'h0001, "R12 erase bits read zero");

    // R1: same write clears enable and asks for erase
    prog(1, 9, 16'h4242, "R9 program stall before rejected erase");
    wr(A_SEG, 16'd1);
    unlock();
    wr(A_CTL, 16'h0002);
    chk("R1 erase with enable cleared no stall", int'(stall), 0);
    rd(A_CTL, 16'h0008, "R1 erase rejected flags error");
    peek(1, 9, 16'h4242, "R1 word survives rejected erase");
    wr(A_CTL, 16'h0009);

    // R10: clear and fresh reject in one write, set wins
    wr(A_CTL, 16'h000B);
    rd(A_CTL, 16'h0009, "R10 set wins over clear");
    wr(A_CTL, 16'h0009);

    // R8: both erase bits, whole array erased
    wr(A_SEG, 16'd1);
    unlock();
    wr(A_CTL, 16'h0007);
    wait_idle(n);
    chk("R8 both bits give whole-array stall", n, SECS * SW + TAIL);
    peek(0, 5, 16'hFFFF, "R8 sector0 erased");
    peek(0, SW - 1, 16'hFFFF, "R8 sector0 last erased");
    peek(1, 9, 16'hFFFF, "R8 sector1 erased");
    rd(A_CTL, 16'h0001, "R8 no error after erase");

    repeat (6) @(negedge clk);
    chk("R12 all reads answered", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule